// File: doc/BRIEF.md
# Small 8-bit Multicycle Processor Core

This block is a compact 8-bit processor that runs one-byte instructions fetched over a 16-bit address bus. Every instruction passes through three phases. A fetch phase puts the instruction pointer on the bus with the read strobe high and waits for the memory to signal ready. A decode phase latches the byte and advances the pointer. An execute phase then writes the result.

The core holds eight 8-bit general registers and two flags, carry and zero. It executes register-to-register add, subtract and exclusive-or. It also runs short forward and backward relative jumps, which are either unconditional or conditioned on one flag, and an indirect jump through a register. The memory behind the bus is outside the block.

The register reset values come from a parameter whose default is all zero. This lets a system, or a bench, start the core with known operand values.

Top module: `tiny_core`

## Requirements
- R1: While reset is high and on the first cycle after it is released, the read strobe is high and the address is 0x0000. Registers take their values from REG_RESET (register n from bits 8n+7..8n, all zero by default), and both flags are clear.
- R2: An instruction byte with bits [7:6]=00 is ADD. Bits [5:3] name the destination register and bits [2:0] the source register (R0..R7 as 000..111). It writes dest+src modulo 256, sets carry when the true sum exceeds 255, and sets zero when the 8-bit result is 0.
- R3: Bits [7:6]=01 is SUB. It writes dest-src modulo 256, sets carry when src is greater than dest (a borrow), and sets zero when the result is 0.
- R4: Bits [7:6]=10 is XOR. It writes dest^src, always clears carry, and sets zero when the result is 0.
- R5: Bits [7:6]=11 is a control byte. Bits [5:3] values 000/001 jump forward/backward, and bits [2:0] give the unsigned offset 0..7. The new address is the address after the jump byte plus or minus the offset, modulo 2^16.
- R6: Codes 010/011 jump forward/backward only when carry is 1. Codes 100/101 jump forward/backward only when zero is 1. Otherwise execution continues at the next byte.
- R7: Code 110 loads the address with the register named by bits [2:0], zero-extended to 16 bits.
- R8: Control bytes never change the flags or the registers. Code 111 does nothing except move on to the next byte.
- R9: Each instruction takes exactly three cycles when memory is ready: one cycle with the strobe high, then two with it low, then the next fetch.
- R10: While the strobe is high and ready is low, the strobe stays high and the address is held until ready is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | output | ADDR_W (16) | Instruction fetch address |
| bus_rdata | input | 8 | Instruction byte returned by memory |
| bus_rd | output | 1 | Read strobe, high during the fetch phase |
| bus_rdy | input | 1 | Memory ready; low stretches the fetch phase |

## Verification
The bus address is the only window onto the core's state, so a wrong register or flag value has to be steered onto it. An indirect jump through the destination register shows a wrong result on the address bus within three cycles of the faulty instruction. A conditional jump with a fixed offset turns a wrong flag into a fetch from the wrong one of two addresses, again within one instruction. A slip in the phase sequence shows up at once as a changed spacing between accepted fetches.

// File: rtl/tc_pkg.sv
package tc_pkg;

  localparam int INSN_W = 8;
  localparam int WORD_W = 8;
  localparam int REG_N  = 8;
  localparam int RSEL_W = $clog2(REG_N);

  typedef enum logic [1:0] {ST_FETCH, ST_DECODE, ST_EXEC} tc_state_e;

  typedef enum logic [1:0] {OP_ADD = 2'b00, OP_SUB = 2'b01, OP_XOR = 2'b10, OP_CTL = 2'b11} tc_op_e;

  // condition selected by a relative jump
  typedef enum logic [1:0] {CND_ALWAYS = 2'b00, CND_CARRY = 2'b01, CND_ZERO = 2'b10, CND_NEVER = 2'b11} tc_cond_e;

  typedef struct packed {
    tc_op_e            op;
    logic [RSEL_W-1:0] dst;
    logic [RSEL_W-1:0] src;
    logic              is_alu;
    logic              is_jrel;
    logic              is_jreg;
    logic              back;
    tc_cond_e          cond;
  } tc_insn_t;

  typedef struct packed {
    logic [WORD_W-1:0] res;
    logic              c;
    logic              z;
  } tc_alu_t;

  // one extra bit carries the carry-out or the borrow
  function automatic tc_alu_t alu_eval(tc_op_e op, logic [WORD_W-1:0] a, logic [WORD_W-1:0] b);
    tc_alu_t         r;
    logic [WORD_W:0] w;
    case (op)
      OP_ADD:  w = {1'b0, a} + {1'b0, b};
      OP_SUB:  w = {1'b0, a} - {1'b0, b};
      default: w = {1'b0, a ^ b};
    endcase
    r.res = w[WORD_W-1:0];
    r.c   = w[WORD_W];
    r.z   = (w[WORD_W-1:0] == '0);
    return r;
  endfunction

endpackage

// File: rtl/tc_decode.sv
module tc_decode
  import tc_pkg::*;
(
  input  logic [INSN_W-1:0] ir,
  output tc_insn_t          insn
);
  logic [2:0] ext;

  always_comb begin
    ext          = ir[5:3];
    insn.op      = tc_op_e'(ir[7:6]);
    insn.dst     = ir[5:3];
    insn.src     = ir[2:0];
    insn.is_alu  = (ir[7:6] != 2'b11);
    insn.is_jrel = (ir[7:6] == 2'b11) && (ext[2:1] != 2'b11);
    insn.is_jreg = (ir[7:6] == 2'b11) && (ext == 3'b110);
    insn.back    = ext[0];
    insn.cond    = insn.is_jrel ? tc_cond_e'(ext[2:1]) : CND_NEVER;
  end
endmodule

// File: rtl/tc_regfile.sv
module tc_regfile
  import tc_pkg::*;
#(
  parameter logic [WORD_W*REG_N-1:0] REG_RESET = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [RSEL_W-1:0] wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [RSEL_W-1:0] rd_sel_a,
  input  logic [RSEL_W-1:0] rd_sel_b,
  output logic [WORD_W-1:0] rd_a,
  output logic [WORD_W-1:0] rd_b
);
  logic [WORD_W-1:0] regs [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= REG_RESET[g*WORD_W +: WORD_W];
      else if (wr_en && (wr_sel == RSEL_W'(g)))
        regs[g] <= wr_data;
    end
  end

  assign rd_a = regs[rd_sel_a];
  assign rd_b = regs[rd_sel_b];
endmodule

// File: rtl/tc_alu.sv
module tc_alu
  import tc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  tc_op_e            op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] res,
  output logic              flag_c,
  output logic              flag_z
);
  tc_alu_t r;

  always_comb r = alu_eval(op, a, b);
  assign res = r.res;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_c <= 1'b0;
      flag_z <= 1'b0;
    end else if (upd) begin
      flag_c <= r.c;
      flag_z <= r.z;
    end
  end
endmodule

// File: rtl/tc_seq.sv
module tc_seq
  import tc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_rdy,
  input  logic [INSN_W-1:0] mem_data,
  input  logic              take,
  input  logic              to_reg,
  input  logic              back,
  input  logic [2:0]        offset,
  input  logic [WORD_W-1:0] reg_val,
  output logic [ADDR_W-1:0] ip,
  output logic              strobe,
  output logic [INSN_W-1:0] ir,
  output logic              in_exec,
  output logic              fetch_done
);
  tc_state_e         st;
  logic [ADDR_W-1:0] target;

  function automatic logic [ADDR_W-1:0] rel_step(logic [ADDR_W-1:0] base, logic [2:0] off, logic dir_back);
    logic [ADDR_W-1:0] d;
    d = ADDR_W'(off);
    return dir_back ? base - d : base + d;
  endfunction

  always_comb begin
    if (to_reg) target = {{(ADDR_W-WORD_W){1'b0}}, reg_val};
    else        target = rel_step(ip, offset, back);
  end

  assign strobe     = (st == ST_FETCH);
  assign in_exec    = (st == ST_EXEC);
  assign fetch_done = strobe && mem_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_FETCH;
      ip <= '0;
      ir <= '0;
    end else begin
      case (st)
        ST_FETCH: if (mem_rdy) begin
          ir <= mem_data;
          st <= ST_DECODE;
        end
        ST_DECODE: begin
          ip <= ip + 1'b1;
          st <= ST_EXEC;
        end
        ST_EXEC: begin
          if (take) ip <= target;
          st <= ST_FETCH;
        end
        default: st <= ST_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/tiny_core.sv
module tiny_core
  import tc_pkg::*;
#(
  parameter int                      ADDR_W    = 16,
  parameter logic [WORD_W*REG_N-1:0] REG_RESET = '0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_rdata,
  output logic              bus_rd,
  input  logic              bus_rdy
);
  logic [INSN_W-1:0] ir;
  tc_insn_t          insn;
  logic [WORD_W-1:0] val_a, val_b, alu_res;
  logic              flag_c, flag_z;
  logic              in_exec, fetch_done;
  logic              cond_met, take;
  logic              exec_alu, exec_xor, exec_jump;

  tc_decode u_dec (.ir(ir), .insn(insn));

  always_comb begin
    case (insn.cond)
      CND_ALWAYS: cond_met = 1'b1;
      CND_CARRY:  cond_met = flag_c;
      CND_ZERO:   cond_met = flag_z;
      default:    cond_met = 1'b0;
    endcase
  end

  assign take      = insn.is_jreg || (insn.is_jrel && cond_met);
  assign exec_alu  = in_exec && insn.is_alu;
  assign exec_xor  = exec_alu && (insn.op == OP_XOR);
  assign exec_jump = in_exec && !insn.is_alu;

  tc_regfile #(.REG_RESET(REG_RESET)) u_rf (
    .clk(clk), .rst(rst),
    .wr_en(exec_alu), .wr_sel(insn.dst), .wr_data(alu_res),
    .rd_sel_a(insn.dst), .rd_sel_b(insn.src),
    .rd_a(val_a), .rd_b(val_b)
  );

  tc_alu u_alu (
    .clk(clk), .rst(rst), .upd(exec_alu), .op(insn.op),
    .a(val_a), .b(val_b), .res(alu_res),
    .flag_c(flag_c), .flag_z(flag_z)
  );

  tc_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .mem_rdy(bus_rdy), .mem_data(bus_rdata),
    .take(take), .to_reg(insn.is_jreg), .back(insn.back),
    .offset(insn.src), .reg_val(val_b),
    .ip(bus_addr), .strobe(bus_rd), .ir(ir),
    .in_exec(in_exec), .fetch_done(fetch_done)
  );
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic              bus_rdy,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              fetch_done,
  input logic              exec_xor,
  input logic              exec_jump,
  input logic              flag_c,
  input logic              flag_z
);
  a_r10_hold_fetch: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_rdy) |=> (bus_rd && $stable(bus_addr)));

  a_r9_three_phase: assert property (@(posedge clk) disable iff (rst)
    fetch_done |=> !bus_rd ##1 !bus_rd ##1 bus_rd);

  a_r8_jump_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    exec_jump |=> $stable({flag_c, flag_z}));

  a_r4_xor_clears_carry: assert property (@(posedge clk) disable iff (rst)
    exec_xor |=> !flag_c);
endmodule

bind tiny_core tc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_rdy(bus_rdy), .bus_addr(bus_addr),
  .fetch_done(fetch_done), .exec_xor(exec_xor), .exec_jump(exec_jump),
  .flag_c(flag_c), .flag_z(flag_z)
);

// File: tb/tb_tiny_core.sv
`timescale 1ns/1ps
module tb_tiny_core;
  // R0..R7 start at 00,01,FF,03,05,80,40,10
  localparam logic [63:0] INIT = 64'h10_40_80_05_03_FF_01_00;
  localparam int WDOG = 100000;
  localparam int NV = 10;
  // {instruction, expected dest value, expected C, expected Z}
  localparam logic [17:0] VEC [NV] = '{
    {8'h11, 8'h00, 1'b1, 1'b1},  // ADD R2,R1
    {8'h1C, 8'h08, 1'b0, 1'b0},  // ADD R3,R4
    {8'h2D, 8'h00, 1'b1, 1'b1},  // ADD R5,R5
    {8'h17, 8'h0F, 1'b1, 1'b0},  // ADD R2,R7
    {8'h5C, 8'hFE, 1'b1, 1'b0},  // SUB R3,R4
    {8'h63, 8'h02, 1'b0, 1'b0},  // SUB R4,R3
    {8'h76, 8'h00, 1'b0, 1'b1},  // SUB R6,R6
    {8'h40, 8'h00, 1'b0, 1'b1},  // SUB R0,R0
    {8'h8C, 8'h04, 1'b0, 1'b0},  // XOR R1,R4
    {8'h92, 8'h00, 1'b0, 1'b1}   // XOR R2,R2
  };

  logic        clk = 0, rst = 1, rdy = 1;
  logic [15:0] bus_addr;
  logic [7:0]  bus_rdata;
  logic        bus_rd;
  logic [7:0]  mem [256];
  logic [15:0] log_addr [16];
  int          log_cyc [16];
  int          nlog = 0, cyc = 0, nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  tiny_core #(.ADDR_W(16), .REG_RESET(INIT)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .bus_rd(bus_rd), .bus_rdy(rdy)
  );

  assign bus_rdata = mem[bus_addr[7:0]];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst) nlog <= 0;
    else if (bus_rd && rdy && nlog < 16) begin
      log_addr[nlog] <= bus_addr;
      log_cyc[nlog]  <= cyc;
      nlog <= nlog + 1;
    end
  end

  always @(posedge clk) if (cyc == WDOG) begin
    nfail++;
    $display("FAIL watchdog: run hung act=%0d exp<%0d cycles", cyc, WDOG);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] p0, p1, p2, p3, input logic stall);
    for (int i = 0; i < 256; i++) mem[i] = 8'hF8;
    mem[0] = p0; mem[1] = p1; mem[2] = p2; mem[3] = p3;
    rst = 1;
    rdy = !stall;
    repeat (2) @(posedge clk);
    #1 rst = 0;
  endtask

  task automatic wait_fetches(input int n);
    for (int t = 0; t < 60 && nlog < n; t++) begin
      @(negedge clk); #1;
    end
  endtask

  initial begin
    // R1: reset state
    load(8'hF8, 8'hF8, 8'hF8, 8'hF8, 1'b0);
    chk("R1 strobe after reset", bus_rd, 1);
    chk("R1 address after reset", bus_addr, 16'h0000);
    wait_fetches(2);
    chk("R1 first fetch address", log_addr[0], 16'h0000);
    chk("R9 fetch spacing", log_cyc[1] - log_cyc[0], 3);
    chk("R8 no-op advances", log_addr[1], 16'h0001);

    // R1: reset register value via indirect jump (R5 = 0x80)
    load(8'hF5, 8'hF8, 8'hF8, 8'hF8, 1'b0);
    wait_fetches(2);
    chk("R7 jump through R5", log_addr[1], 16'h0080);
    // R1: flags clear after reset
    load(8'hD3, 8'hF8, 8'hF8, 8'hF8, 1'b0);
    wait_fetches(2);
    chk("R1 carry clear at reset", log_addr[1], 16'h0001);
    load(8'hE3, 8'hF8, 8'hF8, 8'hF8, 1'b0);
    wait_fetches(2);
    chk("R1 zero clear at reset", log_addr[1], 16'h0001);

    // vector table: result through indirect jump, flags through conditional jumps
    for (int v = 0; v < NV; v++) begin
      logic [7:0]  op, exp_res;
      logic        ec, ez;
      string       tag;
      {op, exp_res, ec, ez} = VEC[v];
      tag = (op[7:6] == 2'b00) ? "R2" : (op[7:6] == 2'b01) ? "R3" : "R4";
      load(op, 8'hF0 | {5'b0, op[5:3]}, 8'hF8, 8'hF8, 1'b0);
      wait_fetches(3);
      chk({tag, " result"}, log_addr[2], {8'h00, exp_res});
      load(op, 8'hD3, 8'hF8, 8'hF8, 1'b0);
      wait_fetches(3);
      chk({tag, " R6 carry"}, log_addr[2], ec ? 16'h0005 : 16'h0002);
      load(op, 8'hE3, 8'hF8, 8'hF8, 1'b0);
      wait_fetches(3);
      chk({tag, " R6 zero"}, log_addr[2], ez ? 16'h0005 : 16'h0002);
    end

    // R10: wait states hold the fetch
    load(8'h1C, 8'hF3, 8'hF8, 8'hF8, 1'b1);
    repeat (3) @(negedge clk);
    #1;
    chk("R10 strobe held", bus_rd, 1);
    chk("R10 address held", bus_addr, 16'h0000);
    chk("R10 no fetch accepted", nlog, 0);
    @(posedge clk); #1 rdy = 1;
    wait_fetches(3);
    chk("R10 result after stall", log_addr[2], 16'h0008);

    // R5: backward offset 1 loops on itself while Z set
    load(8'h40, 8'hE9, 8'hF8, 8'hF8, 1'b0);
    wait_fetches(4);
    chk("R5 self loop", log_addr[2], 16'h0001);
    chk("R5 self loop repeat", log_addr[3], 16'h0001);

    // R5: wrap below zero
    load(8'hCA, 8'hF8, 8'hF8, 8'hF8, 1'b0);
    wait_fetches(2);
    chk("R5 backward wrap", log_addr[1], 16'hFFFF);
    // R5: forward zero offset
    load(8'hC0, 8'hF8, 8'hF8, 8'hF8, 1'b0);
    wait_fetches(2);
    chk("R5 forward zero offset", log_addr[1], 16'h0001);
    // R5: forward maximum
    load(8'hC7, 8'hF8, 8'hF8, 8'hF8, 1'b0);
    wait_fetches(2);
    chk("R5 forward offset 7", log_addr[1], 16'h0008);

    // R8: jump keeps carry (ADD sets C, JMP +1, JC +3 from 4)
    load(8'h11, 8'hC1, 8'hF8, 8'hD3, 1'b0);
    wait_fetches(4);
    chk("R8 carry kept across jump", log_addr[3], 16'h0007);
    // R8: no-op keeps carry
    load(8'h11, 8'hF8, 8'hD3, 8'hF8, 1'b0);
    wait_fetches(4);
    chk("R8 carry kept across no-op", log_addr[3], 16'h0006);
    // R8: jump does not write registers (JR R2 after a jump sees 0xFF)
    load(8'hC0, 8'hF2, 8'hF8, 8'hF8, 1'b0);
    wait_fetches(3);
    chk("R8 register kept", log_addr[2], 16'h00FF);
    // R4: XOR clears carry set by ADD
    load(8'h11, 8'h8C, 8'hD3, 8'hF8, 1'b0);
    wait_fetches(4);
    chk("R4 carry cleared", log_addr[3], 16'h0003);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule